// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Command Registers

This block holds the main translation table of a memory management unit: a set-associative array of entries, each made of a tag word (virtual page number, address-space tag, global bit, valid bit, page-size bit) and a frame word (physical frame and access rights, kept as opaque data). Software never addresses the array directly. It stages a tag word, a frame word and an index in three registers, then writes a command code. The block acts on the staged words and leaves its results in the same registers.

Six commands are decoded. Search looks up the staged tag in its set and leaves the matching index, or an error code, in the index register. Fetch copies the entry at the staged index into the tag and frame registers. Two store commands write the staged words at the staged index. One also raises a one-cycle pulse that tells the small front-end translation caches to discard their contents, and the other does not. Allocate picks a slot in the staged tag's set for a new entry. Flush raises the front-end discard pulse and nothing else. Storing an all-zero tag word clears the valid bit, so it erases that entry.

Register writes use a valid/ready handshake. `reg_ready` is low for the single cycle a command spends executing. A write offered in that cycle waits until `reg_ready` returns, and the caller must hold `reg_valid` and the data until then.

Top module: `tlb_cmd_unit`

## Requirements
- R1: After reset, `tag_o`, `frame_o` and `index_o` are zero, `busy_o` and `flush_utlb_o` are low, `reg_ready` is high, and every entry is invalid, so a search misses.
- R2: A register write is taken only on a clock edge with `reg_valid` and `reg_ready` both high. `reg_ready` is low exactly when `busy_o` is high, so a write offered while busy changes no register. `reg_sel` encodes 0 = tag, 1 = frame, 2 = index, 3 = command, and the command code is `reg_wdata[2:0]`.
- R3: Writing the command register sets `busy_o` for exactly one cycle. The results appear in the registers on the edge where `busy_o` falls.
- R4: Entry index = set × WAYS + way. A search or allocate takes its set from the tag-word bits [13 + log2(SETS) − 1 : 13]. With the defaults of 128 sets × 4 ways, indexes run from 0 to 511.
- R5: Search (code 1) writes the index of the only way that matches. A way matches when its valid bit (bit 9) is set, its virtual page (bits 31:13) equals the staged one, and either its address-space tag (bits 7:0) equals the staged one or its global bit (bit 8) is set.
- R6: When no way matches, search writes 0x8000_0000 to the index register.
- R7: When two or more ways match, search writes the duplicate code 0xC000_0000.
- R8: Allocate (code 5) writes the index of the lowest-numbered invalid way in the staged tag's set.
- R9: When every way of that set is valid, allocate returns the way held in a round-robin pointer. The pointer starts at 0 after reset and advances by one, modulo WAYS, only on such a full-set allocate.
- R10: Store (code 3) writes the tag and frame at index-register bits [log2(SETS×WAYS)−1:0] and pulses `flush_utlb_o` high for one cycle, in the cycle after `busy_o` falls. Quiet store (code 4) writes the entry the same way without the pulse.
- R11: Flush (code 6) pulses `flush_utlb_o` for one cycle and changes no entry and no register.
- R12: Storing an all-zero tag and frame at an index erases that entry, so later searches no longer match it.
- R13: Fetch (code 2) loads the tag and frame registers from the entry at the staged index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register write offered |
| reg_ready | output | 1 | Register write can be taken (low while busy) |
| reg_sel | input | 2 | Register selector: 0 tag, 1 frame, 2 index, 3 command |
| reg_wdata | input | 32 | Register write data |
| tag_o | output | 32 | Staged tag register |
| frame_o | output | 32 | Staged frame register |
| index_o | output | 32 | Index register with search error bits 31 and 30 |
| busy_o | output | 1 | Command executing |
| flush_utlb_o | output | 1 | One-cycle pulse that discards the front-end translation caches |

## Verification
A command written on edge k has `busy_o` high from edge k to edge k+1. Its results in the index, tag and frame registers appear at edge k+1, and the discard pulse is high from edge k+1 to edge k+2. The bench drives on falling edges. It reads `busy_o` at the falling edge just after the command is taken, reads the results and the pulse at the next falling edge, and confirms at the falling edge after that that the pulse has gone low. Expected results come from a reference copy of the table held in the bench and kept up to date from the requirement rules, including the round-robin pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PD_W       = 32;
  localparam int VPN_LSB    = 13;
  localparam int VPN_W      = PD_W - VPN_LSB;
  localparam int ASID_W     = 8;
  localparam int GLOBAL_BIT = 8;
  localparam int VALID_BIT  = 9;
  localparam int SIZE_BIT   = 10;
  localparam int ERR_BIT    = 31;
  localparam int DUP_BIT    = 30;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_PROBE    = 3'd1,
    CMD_READ     = 3'd2,
    CMD_WRITE    = 3'd3,
    CMD_WRITE_NI = 3'd4,
    CMD_GETIDX   = 3'd5,
    CMD_UTLB_INV = 3'd6,
    CMD_RSVD     = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    SEL_TAG   = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_INDEX = 2'd2,
    SEL_CMD   = 2'd3
  } sel_e;

  typedef struct packed {
    logic [PD_W-1:0] tag;
    logic [PD_W-1:0] frame;
  } entry_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      waddr_i,
  input  entry_t                wdata_i,
  input  logic [SET_W-1:0]      rd_set_i,
  output entry_t [WAYS-1:0]     ways_o
);
  localparam int ENTRIES = SETS * WAYS;

  entry_t mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign ways_o[w] = mem[{rd_set_i, WAY_W'(w)}];
  end

  // R10
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]              vld_i,
  input  logic [WAYS-1:0]              glb_i,
  input  logic [WAYS-1:0][VPN_W-1:0]   vpn_i,
  input  logic [WAYS-1:0][ASID_W-1:0]  asid_i,
  input  logic [VPN_W-1:0]             key_vpn_i,
  input  logic [ASID_W-1:0]            key_asid_i,
  output logic                         any_hit_o,
  output logic                         multi_o,
  output logic [WAY_W-1:0]             hit_way_o,
  output logic                         any_free_o,
  output logic [WAY_W-1:0]             free_way_o
);
  logic [WAYS-1:0] hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit[w] = vld_i[w] && (vpn_i[w] == key_vpn_i) &&
                    (glb_i[w] || (asid_i[w] == key_asid_i));
  end

  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit[w])    hit_way_o  = WAY_W'(w);
      if (!vld_i[w]) free_way_o = WAY_W'(w);
    end
  end

  assign any_hit_o  = |hit;
  assign multi_o    = $countones(hit) > 1;
  assign any_free_o = ~&vld_i;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  output logic [WAY_W-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_o <= '0;
    else if (advance_i) ptr_o <= ptr_o + 1'b1;
  end

  // R9
  victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(ptr_o));
endmodule

// File: rtl/tlb_cmd_unit.sv
module tlb_cmd_unit
  import tlb_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  output logic        reg_ready,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] tag_o,
  output logic [31:0] frame_o,
  output logic [31:0] index_o,
  output logic        busy_o,
  output logic        flush_utlb_o
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = SET_W + WAY_W;
  localparam logic [31:0] MISS_CODE = 32'(1) << ERR_BIT;
  localparam logic [31:0] DUP_CODE  = (32'(1) << ERR_BIT) | (32'(1) << DUP_BIT);

  logic [31:0] tag_q, frame_q, idx_q;
  logic        busy_q, flush_q;
  cmd_e        cmd_q;

  logic [SET_W-1:0] key_set, idx_set, rd_set;
  logic [WAY_W-1:0] idx_way;
  entry_t [WAYS-1:0] set_ways;
  logic [WAYS-1:0]              way_vld, way_glb;
  logic [WAYS-1:0][VPN_W-1:0]   way_vpn;
  logic [WAYS-1:0][ASID_W-1:0]  way_asid;
  logic             any_hit, multi, any_free;
  logic [WAY_W-1:0] hit_way, free_way, rr_way;
  logic             store_we, rr_adv;

  assign key_set = tag_q[VPN_LSB +: SET_W];
  assign idx_set = idx_q[IDX_W-1:WAY_W];
  assign idx_way = idx_q[WAY_W-1:0];
  assign rd_set  = (cmd_q == CMD_READ) ? idx_set : key_set;

  assign store_we = busy_q && (cmd_q == CMD_WRITE || cmd_q == CMD_WRITE_NI);
  assign rr_adv   = busy_q && (cmd_q == CMD_GETIDX) && !any_free;

  tlb_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (store_we),
    .waddr_i  (idx_q[IDX_W-1:0]),
    .wdata_i  ('{tag: tag_q, frame: frame_q}),
    .rd_set_i (rd_set),
    .ways_o   (set_ways)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_fields
    assign way_vld[w]  = set_ways[w].tag[VALID_BIT];
    assign way_glb[w]  = set_ways[w].tag[GLOBAL_BIT];
    assign way_vpn[w]  = set_ways[w].tag[PD_W-1:VPN_LSB];
    assign way_asid[w] = set_ways[w].tag[ASID_W-1:0];
  end

  tlb_probe #(.WAYS(WAYS)) u_probe (
    .vld_i      (way_vld),
    .glb_i      (way_glb),
    .vpn_i      (way_vpn),
    .asid_i     (way_asid),
    .key_vpn_i  (tag_q[PD_W-1:VPN_LSB]),
    .key_asid_i (tag_q[ASID_W-1:0]),
    .any_hit_o  (any_hit),
    .multi_o    (multi),
    .hit_way_o  (hit_way),
    .any_free_o (any_free),
    .free_way_o (free_way)
  );

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (rr_adv),
    .ptr_o     (rr_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      frame_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      flush_q <= 1'b0;
      cmd_q   <= CMD_NOP;
    end else begin
      flush_q <= 1'b0;
      if (!busy_q) begin
        if (reg_valid) begin
          case (sel_e'(reg_sel))
            SEL_TAG:   tag_q   <= reg_wdata;
            SEL_FRAME: frame_q <= reg_wdata;
            SEL_INDEX: idx_q   <= reg_wdata;
            SEL_CMD: begin
              cmd_q  <= cmd_e'(reg_wdata[2:0]);
              busy_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end else begin
        busy_q <= 1'b0;
        case (cmd_q)
          CMD_PROBE: begin
            if (!any_hit)   idx_q <= MISS_CODE;
            else if (multi) idx_q <= DUP_CODE;
            else            idx_q <= 32'({key_set, hit_way});
          end
          CMD_READ: begin
            tag_q   <= set_ways[idx_way].tag;
            frame_q <= set_ways[idx_way].frame;
          end
          CMD_GETIDX:   idx_q   <= 32'({key_set, any_free ? free_way : rr_way});
          CMD_WRITE:    flush_q <= 1'b1;
          CMD_UTLB_INV: flush_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign reg_ready    = !busy_q;
  assign busy_o       = busy_q;
  assign flush_utlb_o = flush_q;
  assign tag_o        = tag_q;
  assign frame_o      = frame_q;
  assign index_o      = idx_q;

  // R3
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |=> !busy_q);

  // R10
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);

  // R2
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_q != CMD_READ) |=> $stable(tag_q));

  // R8
  getidx_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_q == CMD_GETIDX) |=>
      (idx_q[31:30] == 2'b00) && (idx_q[IDX_W-1:WAY_W] == $past(key_set)));

  // R5
  probe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_q == CMD_PROBE) |=>
      idx_q[ERR_BIT] || (idx_q[IDX_W-1:WAY_W] == $past(key_set)));
endmodule

// File: tb/tlb_cmd_unit_tb.sv
module tlb_cmd_unit_tb;
  localparam int SETS = 128;
  localparam int WAYS = 4;
  localparam int ENT  = SETS * WAYS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_ready;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] tag_o, frame_o, index_o;
  logic        busy_o, flush_utlb_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_tag [ENT];
  logic [31:0] m_frame [ENT];
  int m_rr = 0;
  logic flush_seen;

  always #5 clk = ~clk;

  tlb_cmd_unit #(.SETS(SETS), .WAYS(WAYS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .tag_o(tag_o), .frame_o(frame_o),
    .index_o(index_o), .busy_o(busy_o), .flush_utlb_o(flush_utlb_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int vpn, input int asid, input bit v, input bit g);
    return {19'(vpn), 2'b00, 1'b0, v, g, 8'(asid)};
  endfunction

  function automatic logic [31:0] exp_probe(input logic [31:0] key);
    int set = int'(key[19:13]);
    int cnt = 0;
    int hit = 0;
    for (int w = 0; w < WAYS; w++) begin
      logic [31:0] e = m_tag[set*WAYS+w];
      if (e[9] && e[31:13] == key[31:13] && (e[7:0] == key[7:0] || e[8])) begin
        cnt++;
        hit = w;
      end
    end
    if (cnt == 0) return 32'h8000_0000;
    if (cnt > 1)  return 32'hC000_0000;
    return 32'(set*WAYS + hit);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  // Command taken at edge k; busy until k+1; flush pulse k+1..k+2.
  task automatic cmd(input int code);
    wr(2'd3, 32'(code));
    check("R3 busy after command", 32'(busy_o), 32'd1);
    @(negedge clk);
    check("R3 busy cleared", 32'(busy_o), 32'd0);
    flush_seen = flush_utlb_o;
    @(negedge clk);
    check("R10 flush pulse single", 32'(flush_utlb_o), 32'd0);
  endtask

  task automatic do_store(input int idx, input logic [31:0] t, input logic [31:0] f, input bit quiet);
    wr(2'd2, 32'(idx)); wr(2'd0, t); wr(2'd1, f);
    cmd(quiet ? 4 : 3);
    check(quiet ? "R10 quiet store no flush" : "R10 store flush", 32'(flush_seen), quiet ? 32'd0 : 32'd1);
    m_tag[idx] = t; m_frame[idx] = f;
  endtask

  task automatic do_probe(input string req, input logic [31:0] key);
    wr(2'd0, key);
    cmd(1);
    check(req, index_o, exp_probe(key));
  endtask

  task automatic do_getidx(input string req, input logic [31:0] key);
    int set = int'(key[19:13]);
    int way = -1;
    wr(2'd0, key);
    cmd(5);
    for (int w = WAYS - 1; w >= 0; w--) if (!m_tag[set*WAYS+w][9]) way = w;
    if (way < 0) begin
      way = m_rr;
      m_rr = (m_rr + 1) % WAYS;
    end
    check(req, index_o, 32'(set*WAYS + way));
  endtask

  task automatic do_fetch(input int idx);
    wr(2'd2, 32'(idx));
    cmd(2);
    check("R13 fetch tag", tag_o, m_tag[idx]);
    check("R13 fetch frame", frame_o, m_frame[idx]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < ENT; i++) begin m_tag[i] = '0; m_frame[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tag", tag_o, '0);
    check("R1 frame", frame_o, '0);
    check("R1 index", index_o, '0);
    check("R1 busy", 32'(busy_o), 0);
    check("R1 flush", 32'(flush_utlb_o), 0);
    rst_n = 1'b1;
    check("R1 ready", 32'(reg_ready), 1);
    do_probe("R1 R6 empty table miss", mk(5, 3, 1, 0));

    // R8 R4 allocate into empty set 5 -> index 20
    do_getidx("R8 R4 first free way", mk(5, 3, 1, 0));
    check("R4 index 20", index_o, 32'd20);
    wr(2'd1, 32'hAAAA_0001);
    cmd(3);
    check("R10 store flush", 32'(flush_seen), 1);
    m_tag[20] = mk(5, 3, 1, 0); m_frame[20] = 32'hAAAA_0001;
    do_probe("R5 exact hit", mk(5, 3, 1, 0));
    check("R5 hit index", index_o, 32'd20);
    do_probe("R6 asid mismatch miss", mk(5, 4, 1, 0));
    check("R6 miss code", index_o, 32'h8000_0000);

    // global entry in same set
    do_getidx("R8 next free way", mk(32'h85, 9, 1, 1));
    check("R8 index 21", index_o, 32'd21);
    do_store(21, mk(32'h85, 9, 1, 1), 32'hBBBB_0002, 1'b1);
    do_probe("R5 global match", mk(32'h85, 1, 1, 0));
    check("R5 global index", index_o, 32'd21);
    do_fetch(21);
    do_fetch(20);

    // R7 duplicate
    do_store(22, mk(5, 3, 1, 0), 32'hCCCC_0003, 1'b0);
    do_probe("R7 duplicate", mk(5, 3, 1, 0));
    check("R7 dup code", index_o, 32'hC000_0000);

    // R9 round robin
    do_store(23, mk(32'h105, 7, 1, 0), 32'hDDDD_0004, 1'b0);
    do_getidx("R9 victim 0", mk(32'h205, 7, 1, 0));
    check("R9 rr index 20", index_o, 32'd20);
    do_getidx("R9 victim 1", mk(32'h205, 7, 1, 0));
    check("R9 rr index 21", index_o, 32'd21);

    // R12 erase
    do_store(22, '0, '0, 1'b0);
    do_probe("R12 dup removed", mk(5, 3, 1, 0));
    check("R12 single left", index_o, 32'd20);
    do_store(20, '0, '0, 1'b1);
    do_probe("R12 erased miss", mk(5, 3, 1, 0));

    // R11 flush only
    wr(2'd0, 32'h1234_5678); wr(2'd2, 32'd21);
    cmd(6);
    check("R11 flush pulse", 32'(flush_seen), 1);
    check("R11 tag kept", tag_o, 32'h1234_5678);
    check("R11 index kept", index_o, 32'd21);
    do_fetch(21);

    // R2 write while busy ignored
    wr(2'd0, 32'h0000_A000);
    @(negedge clk);
    reg_valid = 1'b1; reg_sel = 2'd3; reg_wdata = 32'd1;
    @(negedge clk);
    check("R2 ready low while busy", 32'(reg_ready), 0);
    reg_sel = 2'd0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_valid = 1'b0;
    check("R2 tag unchanged", tag_o, 32'h0000_A000);
    check("R2 ready back", 32'(reg_ready), 1);

    // random mix over sets 5 and 6
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 3));
      int vpns [4] = '{5, 32'h85, 32'h105, 6};
      int vpn = vpns[$urandom_range(0, 3)];
      int asid = int'($urandom_range(1, 2));
      logic [31:0] key = mk(vpn, asid, 1, 0);
      case (op)
        0: begin
          int idx = (5 + int'($urandom_range(0, 1))) * WAYS + int'($urandom_range(0, 3));
          do_store(idx, mk(vpn, asid, $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0),
                   $urandom, $urandom_range(0, 1) == 1);
        end
        1: do_probe("R5 R6 R7 random search", key);
        2: do_getidx("R8 R9 random allocate", key);
        default: do_fetch((5 + int'($urandom_range(0, 1))) * WAYS + int'($urandom_range(0, 3)));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule